// File: doc/BRIEF.md
# Bundle Template Decode and Dispersal

This block sits at the front of an in-order wide-issue core. It accepts 128-bit instruction bundles over a valid/ready stream and holds up to two of them. Each bundle carries a 5-bit template and three 41-bit instruction slots. The template names the execution-unit class of every slot and marks where stops fall. A stop is a group boundary placed by the compiler. The block walks the held slots in program order and, in one cycle, sends as many as it can to nine typed issue ports. It halts at a stop, at a slot whose class has no port left, or after the second bundle.

Grouping needs no dependency logic. A stop ends the group. With no stop at its end, a bundle's group runs on into the next bundle, so up to six slots can leave in one cycle. A bundle leaves the buffer only when all three of its slots have issued. Slots that could not issue stay at the head and go first in the next cycle.

Top module: `bundle_disperse`

## Requirements
- R1: A bundle holds the template in bits [4:0] and slot k (k = 0, 1, 2) in bits [5+41k +: 41]. The 41 bits of an issued slot appear unchanged on its port.
- R2: Templates 0 to 11 are legal. Classes are listed for slot 0/1/2, and stop positions follow each list:
  - 0: M A I, no stop
  - 1: M A I, stop after slot 2
  - 2: M L X, no stop
  - 3: M L X, stop after slot 2
  - 4: M M I, stop after slot 0
  - 5: M F I, no stop
  - 6: M F I, stop after slot 2
  - 7: M I B, no stop
  - 8: M B B, stop after slot 2
  - 9: B B B, no stop
  - 10: M M F, no stop
  - 11: A A B, stops after slots 1 and 2

  Class letters: M memory, I non-ALU integer, A integer ALU, F floating point, B branch, L+X extended immediate pair.
- R3: When the head bundle has a template of 12 to 31, `tmpl_err` is high for one cycle. No port is valid in that cycle, and the bundle is discarded.
- R4: `port_valid`/`port_instr` index 0-1 are M ports, 2-3 I ports, 4-5 F ports and 6-8 B ports. Within one class the lowest free index is used first, in slot order. At most six ports are valid per cycle.
- R5: An A slot takes a free I port if there is one, otherwise a free M port.
- R6: An L+X pair issues only when both I ports are unused in that cycle. L goes to port 2 and X to port 3.
- R7: A slot with a stop after it still issues. No later slot issues in the same cycle.
- R8: When the first held bundle has no stop after its last slot, slots of the second held bundle issue in the same cycle.
- R9: Issue halts at the first slot whose class has no free port. That slot and all later ones issue in order in later cycles.
- R10: `in_ready` is high exactly when fewer than two bundles are held. A bundle is released only after all three of its slots have issued. An accepted bundle can issue from the next cycle.
- R11: During and after reset, with nothing held, no port is valid, `tmpl_err` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Room for a bundle |
| in_bundle | input | 128 | Template and three slots |
| port_valid | output | 9 | Per-port issue strobe (M0 M1 I0 I1 F0 F1 B0 B1 B2) |
| port_instr | output | 369 | Per-port 41-bit instruction, port p at [41p +: 41] |
| tmpl_err | output | 1 | Head bundle had an illegal template |

## Verification
The hardest case is a cycle that retires the first bundle while the second one is cut short. Its group runs on across the bundle edge, and then a port class fills up or a stop is reached partway through the second bundle. In that cycle the buffer must pop one bundle, keep the other, and set a new slot pointer. The sweep feeds every ordered pair of the twelve legal templates and two illegal codes. It does this once back to back, so both bundles are held together, and once with gaps, so bundles arrive alone. A cycle-level model in the bench, built from the template table, predicts every port, the error flag and ready in each cycle.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;
    localparam int SLOT_W   = 41;
    localparam int TMPL_W   = 5;
    localparam int SLOTS    = 3;
    localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W;
    localparam int QDEPTH   = 2;

    typedef enum logic [2:0] {
        UC_ALU  = 3'd0,
        UC_INT  = 3'd1,
        UC_MEM  = 3'd2,
        UC_FP   = 3'd3,
        UC_BR   = 3'd4,
        UC_LONG = 3'd5,
        UC_EXT  = 3'd6
    } ucls_e;

    typedef struct packed {
        logic                  legal;
        logic [SLOTS-1:0][2:0] cls;
        logic [SLOTS-1:0]      stop;
    } tdec_t;

    typedef struct packed {
        logic [QDEPTH-1:0]               vld;
        logic [QDEPTH-1:0][BUNDLE_W-1:0] data;
        logic [1:0]                      ptr;
    } qstate_t;
endpackage

// File: rtl/bdisp_tmpl_dec.sv
module bdisp_tmpl_dec
    import bdisp_pkg::*;
(
    input  logic [TMPL_W-1:0] tmpl,
    output tdec_t             dec
);
    function automatic tdec_t row(ucls_e c0, ucls_e c1, ucls_e c2, logic [SLOTS-1:0] st);
        tdec_t r;
        r.legal = 1'b1;
        r.cls   = {c2, c1, c0};
        r.stop  = st;
        return r;
    endfunction

    always_comb begin
        case (tmpl)
            5'd0:    dec = row(UC_MEM, UC_ALU,  UC_INT, 3'b000);
            5'd1:    dec = row(UC_MEM, UC_ALU,  UC_INT, 3'b100);
            5'd2:    dec = row(UC_MEM, UC_LONG, UC_EXT, 3'b000);
            5'd3:    dec = row(UC_MEM, UC_LONG, UC_EXT, 3'b100);
            5'd4:    dec = row(UC_MEM, UC_MEM,  UC_INT, 3'b001);
            5'd5:    dec = row(UC_MEM, UC_FP,   UC_INT, 3'b000);
            5'd6:    dec = row(UC_MEM, UC_FP,   UC_INT, 3'b100);
            5'd7:    dec = row(UC_MEM, UC_INT,  UC_BR,  3'b000);
            5'd8:    dec = row(UC_MEM, UC_BR,   UC_BR,  3'b100);
            5'd9:    dec = row(UC_BR,  UC_BR,   UC_BR,  3'b000);
            5'd10:   dec = row(UC_MEM, UC_MEM,  UC_FP,  3'b000);
            5'd11:   dec = row(UC_ALU, UC_ALU,  UC_BR,  3'b110);
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/bdisp_queue.sv
module bdisp_queue
    import bdisp_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [BUNDLE_W-1:0]               in_bundle,
    output logic                              in_ready,
    input  logic [2:0]                        adv,
    output logic [QDEPTH-1:0]                 q_vld,
    output logic [QDEPTH-1:0][BUNDLE_W-1:0]   q_data,
    output logic [1:0]                        q_ptr
);
    qstate_t    st_q, st_d, sh;
    logic [1:0] pops;
    logic [1:0] rem;

    assign in_ready = !st_q.vld[QDEPTH-1];
    assign q_vld    = st_q.vld;
    assign q_data   = st_q.data;
    assign q_ptr    = st_q.ptr;

    always_comb begin
        pops = (adv >= 3'(2 * SLOTS)) ? 2'd2 : (adv >= 3'(SLOTS)) ? 2'd1 : 2'd0;
        rem  = 2'(adv - {1'b0, pops} * 3'(SLOTS));
        sh   = st_q;
        case (pops)
            2'd1: begin
                sh.data[0] = st_q.data[1];
                sh.data[1] = '0;
                sh.vld     = {1'b0, st_q.vld[1]};
            end
            2'd2: begin
                sh.data = '0;
                sh.vld  = '0;
            end
            default: ;
        endcase
        sh.ptr = rem;
        st_d   = sh;
        if (in_valid && in_ready) begin
            if (!sh.vld[0]) begin
                st_d.data[0] = in_bundle;
                st_d.vld[0]  = 1'b1;
            end else begin
                st_d.data[1] = in_bundle;
                st_d.vld[1]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r10_ptr_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld[0] |-> st_q.ptr == 2'd0);
    a_r10_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld[1] |-> st_q.vld[0]);
    a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr < 2'(SLOTS));
    a_r10_hold_unfinished: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld[0] && adv < 3'(SLOTS)) |=> (st_q.vld[0] && $stable(st_q.data[0])));
endmodule

// File: rtl/bdisp_walk.sv
module bdisp_walk
    import bdisp_pkg::*;
#(
    parameter  int NM    = 2,
    parameter  int NI    = 2,
    parameter  int NF    = 2,
    parameter  int NB    = 3,
    localparam int NPORT = NM + NI + NF + NB,
    localparam int PW    = $clog2(NPORT),
    localparam int OFF_I = NM,
    localparam int OFF_F = NM + NI,
    localparam int OFF_B = NM + NI + NF
)(
    input  logic [QDEPTH-1:0]               b_vld,
    input  logic [QDEPTH-1:0][BUNDLE_W-1:0] b_data,
    input  logic [1:0]                      ptr,
    input  tdec_t [QDEPTH-1:0]              dec,
    output logic [NPORT-1:0]                p_vld,
    output logic [NPORT-1:0][SLOT_W-1:0]    p_ins,
    output logic                            err,
    output logic [2:0]                      adv
);
    int              n_m, n_i, n_f, n_b;
    logic            halt, skip, hit, is_long, st_here;
    logic [PW-1:0]   tgt;
    logic [SLOT_W-1:0] ins_a, ins_b;

    always_comb begin
        p_vld   = '0;
        p_ins   = '0;
        err     = 1'b0;
        halt    = 1'b0;
        skip    = 1'b0;
        hit     = 1'b0;
        is_long = 1'b0;
        st_here = 1'b0;
        tgt     = '0;
        ins_a   = '0;
        ins_b   = '0;
        n_m = 0; n_i = 0; n_f = 0; n_b = 0;
        adv = {1'b0, ptr};
        if (b_vld[0] && !dec[0].legal) begin
            err  = 1'b1;
            halt = 1'b1;
            adv  = 3'(SLOTS);
        end
        for (int k = 0; k < QDEPTH; k++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (!halt && !(k == 0 && s < int'(ptr))) begin
                    if (skip) begin
                        skip = 1'b0;
                    end else if (!b_vld[k] || !dec[k].legal) begin
                        halt = 1'b1;
                    end else begin
                        hit     = 1'b0;
                        is_long = 1'b0;
                        tgt     = '0;
                        case (ucls_e'(dec[k].cls[s]))
                            UC_MEM: if (n_m < NM) begin hit = 1'b1; tgt = PW'(n_m); end
                            UC_INT: if (n_i < NI) begin hit = 1'b1; tgt = PW'(OFF_I + n_i); end
                            UC_ALU: begin
                                if (n_i < NI) begin
                                    hit = 1'b1; tgt = PW'(OFF_I + n_i);
                                end else if (n_m < NM) begin
                                    hit = 1'b1; tgt = PW'(n_m);
                                end
                            end
                            UC_FP:  if (n_f < NF) begin hit = 1'b1; tgt = PW'(OFF_F + n_f); end
                            UC_BR:  if (n_b < NB) begin hit = 1'b1; tgt = PW'(OFF_B + n_b); end
                            UC_LONG: begin
                                if (n_i == 0 && NI >= 2 && s + 1 < SLOTS) begin
                                    hit = 1'b1; is_long = 1'b1; tgt = PW'(OFF_I);
                                end
                            end
                            default: ;
                        endcase
                        if (!hit) begin
                            halt = 1'b1;
                        end else begin
                            ins_a      = b_data[k][TMPL_W + s*SLOT_W +: SLOT_W];
                            p_vld[tgt] = 1'b1;
                            p_ins[tgt] = ins_a;
                            if (int'(tgt) < OFF_I)      n_m++;
                            else if (int'(tgt) < OFF_F) n_i++;
                            else if (int'(tgt) < OFF_B) n_f++;
                            else                        n_b++;
                            st_here = dec[k].stop[s];
                            adv     = 3'(k*SLOTS + s + 1);
                            if (is_long) begin
                                ins_b = b_data[k][TMPL_W + ((s+1)%SLOTS)*SLOT_W +: SLOT_W];
                                p_vld[tgt + 1'b1] = 1'b1;
                                p_ins[tgt + 1'b1] = ins_b;
                                n_i++;
                                st_here = dec[k].stop[(s+1)%SLOTS];
                                adv     = 3'(k*SLOTS + s + 2);
                                skip    = 1'b1;
                            end
                            if (st_here) halt = 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse
    import bdisp_pkg::*;
#(
    parameter  int NM    = 2,
    parameter  int NI    = 2,
    parameter  int NF    = 2,
    parameter  int NB    = 3,
    localparam int NPORT = NM + NI + NF + NB,
    localparam int OFF_I = NM,
    localparam int OFF_F = NM + NI,
    localparam int OFF_B = NM + NI + NF
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [BUNDLE_W-1:0]       in_bundle,
    output logic [NPORT-1:0]          port_valid,
    output logic [NPORT*SLOT_W-1:0]   port_instr,
    output logic                      tmpl_err
);
    logic [QDEPTH-1:0]               q_vld;
    logic [QDEPTH-1:0][BUNDLE_W-1:0] q_data;
    logic [1:0]                      q_ptr;
    logic [2:0]                      adv;
    tdec_t [QDEPTH-1:0]              dec;
    logic [NPORT-1:0][SLOT_W-1:0]    p_ins;

    bdisp_queue u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bundle (in_bundle),
        .in_ready  (in_ready),
        .adv       (adv),
        .q_vld     (q_vld),
        .q_data    (q_data),
        .q_ptr     (q_ptr)
    );

    for (genvar g = 0; g < QDEPTH; g++) begin : g_dec
        bdisp_tmpl_dec u_dec (
            .tmpl (q_data[g][TMPL_W-1:0]),
            .dec  (dec[g])
        );
    end

    bdisp_walk #(.NM(NM), .NI(NI), .NF(NF), .NB(NB)) u_walk (
        .b_vld  (q_vld),
        .b_data (q_data),
        .ptr    (q_ptr),
        .dec    (dec),
        .p_vld  (port_valid),
        .p_ins  (p_ins),
        .err    (tmpl_err),
        .adv    (adv)
    );

    assign port_instr = p_ins;

    a_r4_budget: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(port_valid) <= 2 * SLOTS);
    a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tmpl_err |-> port_valid == '0);
    a_r11_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !q_vld[0] |-> (port_valid == '0 && !tmpl_err));
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid == '0 && !tmpl_err) |=> $stable(q_ptr));

    for (genvar p = 1; p < NPORT; p++) begin : g_order
        if (p != OFF_I && p != OFF_F && p != OFF_B) begin : g_chk
            a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
                port_valid[p] |-> port_valid[p-1]);
        end
    end
endmodule

// File: tb/bundle_disperse_tb.sv
module bundle_disperse_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT  = 9;
    localparam int STREAM = 392;
    localparam int CM = 1, CI = 2, CA = 3, CF = 4, CB = 5, CL = 6, CX = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_bundle = '0;
    logic         in_ready;
    logic [8:0]   port_valid;
    logic [368:0] port_instr;
    logic         tmpl_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bundle_disperse u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_bundle  (in_bundle),
        .port_valid (port_valid),
        .port_instr (port_instr),
        .tmpl_err   (tmpl_err)
    );

    // model state
    logic [127:0] mq [2];
    int           mcnt = 0;
    int           mptr = 0;
    logic [8:0]   exp_vld;
    logic [40:0]  exp_ins [NPORT];
    bit           exp_err;
    int           exp_tot;
    string        exp_tag;

    function automatic int tb_cls(int t, int s);
        int r[3];
        case (t)
            0, 1:    r = '{CM, CA, CI};
            2, 3:    r = '{CM, CL, CX};
            4:       r = '{CM, CM, CI};
            5, 6:    r = '{CM, CF, CI};
            7:       r = '{CM, CI, CB};
            8:       r = '{CM, CB, CB};
            9:       r = '{CB, CB, CB};
            10:      r = '{CM, CM, CF};
            11:      r = '{CA, CA, CB};
            default: r = '{0, 0, 0};
        endcase
        return r[s];
    endfunction

    function automatic bit tb_stop(int t, int s);
        case (t)
            1, 3, 6, 8: return s == 2;
            4:          return s == 0;
            11:         return s >= 1;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [127:0] bundle_of(int i);
        logic [127:0] b;
        int pr, x, code;
        pr = i / 2;
        x  = (i % 2 == 0) ? pr / 14 : pr % 14;
        code = (x < 12) ? x : (x == 12 ? 12 : 31);
        b = '0;
        b[4:0] = 5'(code);
        for (int s = 0; s < 3; s++) b[5 + 41*s +: 41] = 41'(i * 4 + s + 1);
        return b;
    endfunction

    task automatic model_eval();
        int cl[6];
        bit sp[6];
        logic [40:0] dv[6];
        int src[6];
        int n, j, um, ui, uf, ub, p, t, s0;
        bit alu_m, from_b1, port_halt, stop_halt, lx;
        exp_vld = '0;
        for (int q = 0; q < NPORT; q++) exp_ins[q] = '0;
        exp_err = 0;
        exp_tot = mptr;
        exp_tag = "R2";
        if (mcnt == 0) return;
        if (tb_cls(int'(mq[0][4:0]), 0) == 0) begin
            exp_err = 1; exp_tot = 3; exp_tag = "R3";
            return;
        end
        n = 0;
        for (int b = 0; b < mcnt; b++) begin
            t = int'(mq[b][4:0]);
            if (tb_cls(t, 0) == 0) break;
            s0 = (b == 0) ? mptr : 0;
            for (int s = s0; s < 3; s++) begin
                cl[n] = tb_cls(t, s); sp[n] = tb_stop(t, s);
                dv[n] = mq[b][5 + 41*s +: 41]; src[n] = b; n++;
            end
        end
        j = 0; um = 0; ui = 0; uf = 0; ub = 0;
        alu_m = 0; from_b1 = 0; port_halt = 0; stop_halt = 0; lx = 0;
        while (j < n && !port_halt && !stop_halt) begin
            p = -1;
            case (cl[j])
                CM: if (um < 2) begin p = um; um++; end
                CI: if (ui < 2) begin p = 2 + ui; ui++; end
                CA: if (ui < 2) begin p = 2 + ui; ui++; end
                    else if (um < 2) begin p = um; um++; alu_m = 1; end
                CF: if (uf < 2) begin p = 4 + uf; uf++; end
                CB: if (ub < 3) begin p = 6 + ub; ub++; end
                CL: if (ui == 0) begin p = 2; ui = 2; end
                default: ;
            endcase
            if (p < 0) port_halt = 1;
            else begin
                exp_vld[p] = 1'b1; exp_ins[p] = dv[j];
                if (src[j] == 1) from_b1 = 1;
                if (cl[j] == CL) begin
                    exp_vld[3] = 1'b1; exp_ins[3] = dv[j+1]; lx = 1; j += 2;
                end else j++;
                exp_tot = mptr + j;
                if (sp[j-1]) stop_halt = 1;
            end
        end
        if (lx)             exp_tag = "R6";
        else if (alu_m)     exp_tag = "R5";
        else if (from_b1)   exp_tag = "R8";
        else if (port_halt) exp_tag = "R9";
        else if (stop_halt) exp_tag = "R7";
    endtask

    task automatic chk(bit ok, string req, string what, logic [63:0] got, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h", req, what, got, expv);
        end
    endtask

    task automatic check_outputs();
        chk(in_ready == (mcnt < 2), "R10", "in_ready", 64'(in_ready), 64'(mcnt < 2));
        chk(tmpl_err == exp_err, "R3", "tmpl_err", 64'(tmpl_err), 64'(exp_err));
        chk(port_valid == exp_vld, exp_tag, "R4 port_valid", 64'(port_valid), 64'(exp_vld));
        for (int p = 0; p < NPORT; p++)
            if (exp_vld[p] && port_valid[p])
                chk(port_instr[41*p +: 41] == exp_ins[p], "R1", "port_instr",
                    64'(port_instr[41*p +: 41]), 64'(exp_ins[p]));
    endtask

    task automatic model_update(bit accept);
        int pops, rem;
        pops = exp_tot / 3;
        rem  = exp_tot % 3;
        if (pops == 1) begin mq[0] = mq[1]; mcnt = mcnt - 1; end
        else if (pops == 2) mcnt = 0;
        mptr = rem;
        if (accept) begin mq[mcnt] = in_bundle; mcnt++; end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int idx, cyc;
        bit accept;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(port_valid == '0, "R11", "port_valid in reset", 64'(port_valid), 64'd0);
        chk(tmpl_err == 1'b0, "R11", "tmpl_err in reset", 64'(tmpl_err), 64'd0);
        chk(in_ready == 1'b1, "R11", "in_ready in reset", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        for (int pass = 0; pass < 2; pass++) begin
            idx = 0; cyc = 0;
            while (idx < STREAM || mcnt > 0) begin
                @(negedge clk);
                model_eval();
                check_outputs();
                if (idx < STREAM && (pass == 0 || cyc % 2 == 0)) begin
                    in_valid  = 1'b1;
                    in_bundle = bundle_of(idx);
                end else begin
                    in_valid  = 1'b0;
                end
                accept = in_valid && (mcnt < 2);
                model_update(accept);
                if (accept) idx++;
                cyc++;
            end
            @(negedge clk);
            model_eval();
            check_outputs();
            in_valid = 1'b0;
        end
        done = 1;
        summary();
        $finish;
    end
endmodule